// File: doc/BRIEF.md
# Trigger Combining and Holdoff Logic

This block turns a set of trigger sources into one trigger event for a sampling path. There are two external digital pins, one compare result per analog channel (A and B), and one trigger line from a logic analyzer. Each pin is first brought into the clock domain. It is then qualified by any mix of rising-edge, falling-edge, any-edge, high-level and low-level conditions, and the enabled conditions are ORed.

Two paths each pick one of ten ways to form their term from a digital term and an analog term. Path A takes pin 0 and channel A; path B takes pin 1 and channel B. A final selector merges the two path terms and the logic-analyzer line.

The merged condition becomes a trigger event only when the holdoff timer is idle. Each event reloads the timer, asserts the registered trigger output, and sets a sticky status flag that stays set until it is cleared. In streaming mode the output stays high after the first event until streaming is turned off. All configuration arrives as plain input ports, held stable by the surrounding logic.

Top module: `trig_combine`

## Requirements
- R1: A pin with its high-level enable (or low-level enable) set produces a digital term while the pin is 1 (or 0). It passes through a two-flop synchronizer, so with the path and final select routing it straight through, `trig_out` follows a pin change on the third rising clock edge after the change.
- R2: A pin with its rising-edge enable set gives a `trig_out` pulse exactly one cycle wide, on the third edge after a 0-to-1 change. A pin with its falling-edge enable set does the same for a 1-to-0 change, and holding the pin produces no further pulses.
- R3: A pin with its any-edge enable set gives a one-cycle pulse for a change in either direction.
- R4: The path mode codes are: 0 always 1, 1 digital term, 2 analog term, 3 never, 4 d|a, 5 d&a, 6 d^a, 7 ~(d|a), 8 ~(d&a), 9 ~(d^a). Any code above 9 is never as well.
- R5: Path A combines pin 0 with `ana_a`, and path B combines pin 1 with `ana_b`. The enables of one pin have no effect on the other path.
- R6: The final select codes are: 0 A, 1 B, 2 A|B, 3 A&B, 4 A^B, 5 LA, 6 A|LA, 7 B|LA, 8 A|B|LA. Any code above 8 yields no trigger.
- R7: `trig_out` is registered. An analog or logic-analyzer condition present before a rising edge shows on `trig_out` after that edge, and with streaming off it is low one edge after the condition goes away.
- R8: With `holdoff` = N > 0, a trigger event blocks further events for the next N cycles. A condition held continuously therefore pulses `trig_out` once every N+1 cycles. With N = 0 nothing is blocked.
- R9: `trig_flag` is set by every trigger event and stays set until a cycle with `clr_flag` high and no event clears it. An event in the same cycle as a clear keeps the flag set.
- R10: While `streaming` is high, `trig_out` stays high from the first event onward. The edge after `streaming` goes low, `trig_out` drops to the current event value.
- R11: During and right after reset, `trig_out` and `trig_flag` are 0 and the holdoff timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 2 | External digital trigger pins (asynchronous) |
| ana_a | input | 1 | Compare result for analog channel A |
| ana_b | input | 1 | Compare result for analog channel B |
| la_trig | input | 1 | Logic-analyzer trigger |
| en_fall | input | 2 | Falling-edge enable, one bit per pin |
| en_rise | input | 2 | Rising-edge enable, one bit per pin |
| en_any | input | 2 | Any-edge enable, one bit per pin |
| en_high | input | 2 | High-level enable, one bit per pin |
| en_low | input | 2 | Low-level enable, one bit per pin |
| mode_a | input | 4 | Path A mode code |
| mode_b | input | 4 | Path B mode code |
| final_sel | input | 4 | Final merge select code |
| holdoff | input | 32 | Holdoff length in cycles |
| streaming | input | 1 | Keep the trigger asserted after the first event |
| clr_flag | input | 1 | Clear the sticky trigger flag |
| trig_out | output | 1 | Registered trigger output |
| trig_flag | output | 1 | Sticky trigger-seen flag |

## Verification
The checker watches, on every cycle, the relations between the state elements. The flag stays set unless cleared, and it never rises without the trigger output rising with it. No output pulse appears while the holdoff timer is busy with streaming off. Streaming keeps the output high once it is high, and out-of-range final codes produce nothing. The truth tables of the path modes and final codes, the synchronizer latency, the width of the edge pulses, the N+1 holdoff period and the release of streaming depend on specific stimulus sequences, so only the bench's directed scenarios can show them.

// File: rtl/trig_pkg.sv
// Shared encodings for the trigger combining block.
// Assumes mode and select fields are four bits wide.
package trig_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        PM_ALWAYS = 4'd0,
        PM_DIG    = 4'd1,
        PM_ANA    = 4'd2,
        PM_RSVD   = 4'd3,
        PM_OR     = 4'd4,
        PM_AND    = 4'd5,
        PM_XOR    = 4'd6,
        PM_NOR    = 4'd7,
        PM_NAND   = 4'd8,
        PM_XNOR   = 4'd9
    } path_mode_e;

    typedef enum logic [MODE_W-1:0] {
        FS_A     = 4'd0,
        FS_B     = 4'd1,
        FS_AORB  = 4'd2,
        FS_AANDB = 4'd3,
        FS_AXORB = 4'd4,
        FS_LA    = 4'd5,
        FS_AORL  = 4'd6,
        FS_BORL  = 4'd7,
        FS_ALL   = 4'd8
    } final_sel_e;

    // Merge the two path terms and the logic-analyzer line; unknown codes give 0.
    function automatic logic final_merge(input logic [MODE_W-1:0] sel,
                                         input logic ta, input logic tb,
                                         input logic tl);
        logic r;
        case (sel)
            FS_A:     r = ta;
            FS_B:     r = tb;
            FS_AORB:  r = ta | tb;
            FS_AANDB: r = ta & tb;
            FS_AXORB: r = ta ^ tb;
            FS_LA:    r = tl;
            FS_AORL:  r = ta | tl;
            FS_BORL:  r = tb | tl;
            FS_ALL:   r = ta | tb | tl;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pin_qual.sv
// Synchronizes one external trigger pin and qualifies it with five
// independently enabled conditions; the digital term is their OR.
// Assumes the pin is asynchronous to clk and that SYNC_STAGES >= 2.
module pin_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic en_fall,
    input  logic en_rise,
    input  logic en_any,
    input  logic en_high,
    input  logic en_low,
    output logic dig
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // OR of all enabled edge and level conditions.
    always_comb begin
        dig = (en_rise & cur & ~prev_q)
            | (en_fall & ~cur & prev_q)
            | (en_any & (cur ^ prev_q))
            | (en_high & cur)
            | (en_low & ~cur);
    end
endmodule

// File: rtl/path_combine.sv
// Forms one path's trigger term from a digital and an analog term under
// a four-bit mode code. Assumes unused codes should never trigger.
module path_combine
    import trig_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              dig,
    input  logic              ana,
    output logic              trig
);
    // Decode the mode into the path term.
    always_comb begin
        case (mode)
            PM_ALWAYS: trig = 1'b1;
            PM_DIG:    trig = dig;
            PM_ANA:    trig = ana;
            PM_OR:     trig = dig | ana;
            PM_AND:    trig = dig & ana;
            PM_XOR:    trig = dig ^ ana;
            PM_NOR:    trig = ~(dig | ana);
            PM_NAND:   trig = ~(dig & ana);
            PM_XNOR:   trig = ~(dig ^ ana);
            default:   trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/holdoff_timer.sv
// Down-counter that reloads on each trigger event and reports busy while
// nonzero. Assumes the holdoff value is held stable by the caller.
module holdoff_timer #(
    parameter int HOLD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] holdoff,
    output logic              busy
);
    logic [HOLD_W-1:0] cnt_q;

    // Reload on an event, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= holdoff;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/trig_gate.sv
// Qualifies the merged condition with the holdoff state and registers the
// trigger output and the sticky flag. Assumes streaming is level-controlled.
module trig_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic busy,
    input  logic streaming,
    input  logic clr_flag,
    output logic evt,
    output logic trig_out,
    output logic trig_flag
);
    assign evt = raw & ~busy;

    // Output follows events, or latches them while streaming.
    always_ff @(posedge clk) begin
        if (!rst_n)         trig_out <= 1'b0;
        else if (streaming) trig_out <= trig_out | evt;
        else                trig_out <= evt;
    end

    // Sticky flag: set by an event, cleared on request, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_flag <= 1'b0;
        else        trig_flag <= (trig_flag & ~clr_flag) | evt;
    end
endmodule

// File: rtl/trig_combine.sv
// Top of the trigger combining block: per-pin qualification, per-path
// combining, final merge, holdoff and output registers.
// Assumes configuration inputs are quasi-static and analog/LA inputs are
// already synchronous to clk.
module trig_combine
    import trig_pkg::*;
#(
    parameter int N_PINS      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              ana_a,
    input  logic              ana_b,
    input  logic              la_trig,
    input  logic [N_PINS-1:0] en_fall,
    input  logic [N_PINS-1:0] en_rise,
    input  logic [N_PINS-1:0] en_any,
    input  logic [N_PINS-1:0] en_high,
    input  logic [N_PINS-1:0] en_low,
    input  logic [MODE_W-1:0] mode_a,
    input  logic [MODE_W-1:0] mode_b,
    input  logic [MODE_W-1:0] final_sel,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic              streaming,
    input  logic              clr_flag,
    output logic              trig_out,
    output logic              trig_flag
);
    localparam int N_PATHS = N_PINS;

    logic [N_PINS-1:0]       dig;
    logic [N_PATHS-1:0]      ana_vec;
    logic [N_PATHS-1:0]      path_trig;
    logic [MODE_W-1:0]       mode_vec [N_PATHS];
    logic                    raw;
    logic                    evt;
    logic                    hold_busy;

    assign ana_vec     = {ana_b, ana_a};
    assign mode_vec[0] = mode_a;
    assign mode_vec[1] = mode_b;

    // One qualifier per pin.
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (pin_in[i]),
            .en_fall (en_fall[i]),
            .en_rise (en_rise[i]),
            .en_any  (en_any[i]),
            .en_high (en_high[i]),
            .en_low  (en_low[i]),
            .dig     (dig[i])
        );
    end

    // One combiner per path; path i pairs pin i with channel i.
    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
        path_combine u_path (
            .mode (mode_vec[p]),
            .dig  (dig[p]),
            .ana  (ana_vec[p]),
            .trig (path_trig[p])
        );
    end

    assign raw = final_merge(final_sel, path_trig[0], path_trig[1], la_trig);

    holdoff_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (evt),
        .holdoff (holdoff),
        .busy    (hold_busy)
    );

    trig_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw       (raw),
        .busy      (hold_busy),
        .streaming (streaming),
        .clr_flag  (clr_flag),
        .evt       (evt),
        .trig_out  (trig_out),
        .trig_flag (trig_flag)
    );
endmodule

// File: rtl/trig_combine_chk.sv
// Property checker for trig_combine, attached by bind below.
module trig_combine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       streaming,
    input logic       clr_flag,
    input logic [3:0] final_sel,
    input logic       hold_busy,
    input logic       trig_out,
    input logic       trig_flag
);
    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !clr_flag) |=> trig_flag);

    // R9
    flag_with_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_flag) |-> trig_out);

    // R9
    clear_tracks_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !streaming) |=> (trig_flag == trig_out));

    // R8
    holdoff_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_busy && !streaming) |=> !trig_out);

    // R10
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (streaming && $past(streaming) && $past(trig_out)) |-> trig_out);

    // R6
    bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((final_sel > 4'd8) && !streaming) |=> !trig_out);
endmodule

bind trig_combine trig_combine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .streaming (streaming),
    .clr_flag  (clr_flag),
    .final_sel (final_sel),
    .hold_busy (hold_busy),
    .trig_out  (trig_out),
    .trig_flag (trig_flag)
);

// File: tb/tb_trig_combine.sv
module tb_trig_combine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  pin_in;
    logic        ana_a, ana_b, la_trig;
    logic [1:0]  en_fall, en_rise, en_any, en_high, en_low;
    logic [3:0]  mode_a, mode_b, final_sel;
    logic [31:0] holdoff;
    logic        streaming, clr_flag;
    logic        trig_out, trig_flag;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    trig_combine dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ana_a(ana_a), .ana_b(ana_b),
        .la_trig(la_trig), .en_fall(en_fall), .en_rise(en_rise), .en_any(en_any),
        .en_high(en_high), .en_low(en_low), .mode_a(mode_a), .mode_b(mode_b),
        .final_sel(final_sel), .holdoff(holdoff), .streaming(streaming),
        .clr_flag(clr_flag), .trig_out(trig_out), .trig_flag(trig_flag)
    );

    task automatic chk(input logic act, input logic exp, input string msg);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", msg, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        en_fall = 0; en_rise = 0; en_any = 0; en_high = 0; en_low = 0;
        ana_a = 0; ana_b = 0; la_trig = 0; mode_a = 4'd0; mode_b = 4'd0;
        final_sel = 4'd15; holdoff = 0; streaming = 0; clr_flag = 0;
    endtask

    function automatic logic path_exp(input int m, input logic d, input logic a);
        case (m)
            0: return 1'b1;
            1: return d;
            2: return a;
            4: return d | a;
            5: return d & a;
            6: return d ^ a;
            7: return ~(d | a);
            8: return ~(d & a);
            9: return ~(d ^ a);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic sel_exp(input int s, input logic a, input logic b, input logic l);
        case (s)
            0: return a;
            1: return b;
            2: return a | b;
            3: return a & b;
            4: return a ^ b;
            5: return l;
            6: return a | l;
            7: return b | l;
            8: return a | b | l;
            default: return 1'b0;
        endcase
    endfunction

    // R11: reset state
    task automatic t_reset();
        chk(trig_out, 1'b0, "R11 trig_out after reset");
        chk(trig_flag, 1'b0, "R11 trig_flag after reset");
    endtask

    // R1: level conditions and synchronizer latency
    task automatic t_level();
        quiet(); pin_in = 2'b00; step(4);
        mode_a = 4'd1; final_sel = 4'd0; en_high[0] = 1'b1;
        step(1); chk(trig_out, 1'b0, "R1 high-level idle");
        pin_in[0] = 1'b1;
        step(1); chk(trig_out, 1'b0, "R1 latency edge1");
        step(1); chk(trig_out, 1'b0, "R1 latency edge2");
        step(1); chk(trig_out, 1'b1, "R1 high level at edge3");
        step(2); chk(trig_out, 1'b1, "R1 high level held");
        en_high[0] = 1'b0; en_low[0] = 1'b1;
        step(1); chk(trig_out, 1'b0, "R1 low-level while pin high");
        pin_in[0] = 1'b0;
        step(2); chk(trig_out, 1'b0, "R1 low-level latency");
        step(1); chk(trig_out, 1'b1, "R1 low level at edge3");
        quiet(); step(3);
    endtask

    // R2/R3: edge pulses
    task automatic edge_run(input logic from, input string tag, input logic expect_pulse);
        pin_in[0] = ~from;
        step(2); chk(trig_out, 1'b0, {tag, " before pulse"});
        step(1); chk(trig_out, expect_pulse, {tag, " pulse"});
        step(1); chk(trig_out, 1'b0, {tag, " pulse ends"});
        step(2); chk(trig_out, 1'b0, {tag, " no repeat"});
    endtask

    task automatic t_edges();
        quiet(); pin_in = 2'b00; step(4);
        mode_a = 4'd1; final_sel = 4'd0;
        en_rise[0] = 1'b1;
        edge_run(1'b0, "R2 rise 0->1", 1'b1);
        edge_run(1'b1, "R2 rise ignores 1->0", 1'b0);
        en_rise[0] = 1'b0; en_fall[0] = 1'b1;
        edge_run(1'b0, "R2 fall ignores 0->1", 1'b0);
        edge_run(1'b1, "R2 fall 1->0", 1'b1);
        en_fall[0] = 1'b0; en_any[0] = 1'b1;
        edge_run(1'b0, "R3 any 0->1", 1'b1);
        edge_run(1'b1, "R3 any 1->0", 1'b1);
        quiet(); step(3);
    endtask

    // R4: path mode truth table (path A, digital term via high-level enable)
    task automatic t_modes();
        quiet(); pin_in = 2'b01; step(4);
        final_sel = 4'd0;
        for (int m = 0; m < 12; m++) begin
            for (int v = 0; v < 4; v++) begin
                mode_a = 4'(m); en_high[0] = v[1]; ana_a = v[0];
                step(1);
                chk(trig_out, path_exp(m, v[1], v[0]),
                    $sformatf("R4 mode %0d d=%0d a=%0d", m, v[1], v[0]));
            end
        end
        quiet(); step(2);
    endtask

    // R5: path B pairs pin 1 with ana_b; pin 0 settings do not reach it
    task automatic t_pathb();
        quiet(); pin_in = 2'b10; step(4);
        final_sel = 4'd1; mode_b = 4'd1; en_high = 2'b01;
        step(1); chk(trig_out, 1'b0, "R5 pin0 enable does not reach path B");
        en_high = 2'b10;
        step(1); chk(trig_out, 1'b1, "R5 pin1 drives path B");
        mode_b = 4'd2; ana_a = 1'b1;
        step(1); chk(trig_out, 1'b0, "R5 ana_a does not reach path B");
        ana_a = 1'b0; ana_b = 1'b1;
        step(1); chk(trig_out, 1'b1, "R5 ana_b drives path B");
        quiet(); step(2);
    endtask

    // R6/R7: final select table using analog terms and LA
    task automatic t_final();
        quiet(); mode_a = 4'd2; mode_b = 4'd2;
        for (int s = 0; s < 12; s++) begin
            for (int v = 0; v < 8; v++) begin
                final_sel = 4'(s); ana_a = v[2]; ana_b = v[1]; la_trig = v[0];
                step(1);
                chk(trig_out, sel_exp(s, v[2], v[1], v[0]),
                    $sformatf("R6 sel %0d a=%0d b=%0d l=%0d", s, v[2], v[1], v[0]));
            end
        end
        quiet(); final_sel = 4'd5; la_trig = 1'b1;
        step(1); chk(trig_out, 1'b1, "R7 registered one edge later");
        la_trig = 1'b0;
        step(1); chk(trig_out, 1'b0, "R7 drops one edge after condition");
        quiet(); step(2);
    endtask

    // R8: holdoff period N+1
    task automatic t_holdoff();
        quiet(); final_sel = 4'd0; mode_a = 4'd2; holdoff = 32'd3;
        ana_a = 1'b1;
        for (int k = 0; k < 9; k++) begin
            step(1);
            chk(trig_out, (k % 4) == 0, $sformatf("R8 holdoff=3 cycle %0d", k));
        end
        holdoff = 32'd0; step(4);
        for (int k = 0; k < 3; k++) begin
            step(1);
            chk(trig_out, 1'b1, $sformatf("R8 holdoff=0 cycle %0d", k));
        end
        quiet(); step(2);
    endtask

    // R9: sticky flag, clear, set wins
    task automatic t_flag();
        quiet(); clr_flag = 1'b1;
        step(1); clr_flag = 1'b0; chk(trig_flag, 1'b0, "R9 cleared");
        step(2); chk(trig_flag, 1'b0, "R9 stays clear");
        final_sel = 4'd0; mode_a = 4'd2; ana_a = 1'b1;
        step(1); ana_a = 1'b0; chk(trig_flag, 1'b1, "R9 set by event");
        step(3); chk(trig_flag, 1'b1, "R9 sticky");
        clr_flag = 1'b1; ana_a = 1'b1;
        step(1); clr_flag = 1'b0; ana_a = 1'b0;
        chk(trig_flag, 1'b1, "R9 set wins over clear");
        quiet(); step(2);
    endtask

    // R10: streaming keeps output high until released
    task automatic t_stream();
        quiet(); final_sel = 4'd0; mode_a = 4'd2; streaming = 1'b1;
        step(2); chk(trig_out, 1'b0, "R10 idle before event");
        ana_a = 1'b1;
        step(1); ana_a = 1'b0; chk(trig_out, 1'b1, "R10 first event");
        step(5); chk(trig_out, 1'b1, "R10 held while streaming");
        streaming = 1'b0;
        step(1); chk(trig_out, 1'b0, "R10 released");
        quiet(); step(2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        quiet(); pin_in = 2'b00; rst_n = 1'b0;
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_level();
        t_edges();
        t_modes();
        t_pathb();
        t_final();
        t_holdoff();
        t_flag();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule